// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Data Cache

This block is a small direct-mapped data cache that sits between a processor load/store port and a word-wide memory port. Its index and byte-select bits lie entirely inside the untranslated page offset. The tag, valid and data arrays can therefore be read as soon as a request is accepted, while the translation buffer is still working on the frame number. One cycle later the translation result arrives on a frame input with a valid flag and a fault flag. The stored tag is then compared against the physical address formed from that frame and the offset.

Read hits return the stored word without touching memory. Read misses fetch the aligned word through the memory port, install it with its physical tag and return it. Writes always go to memory. A write that hits also merges its enabled bytes into the cached line, and a write that misses leaves the array alone. A translation fault ends the access with a fault response and no hit. While translation is not yet valid, the access waits in the lookup stage. The size parameter may not exceed one page, because a larger cache would need a translated bit in its index. The design refuses to elaborate in that case.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid. The first read of any offset reports hit=0 and issues a memory read.
- R2: A read miss issues one memory read at the address {frame, index, 2'b00}, with the frame in bits 31:12, the index in bits 11:2 and zero byte select. It returns that memory word with hit=0.
- R3: A read to the same frame and index as a previously filled line reports hit=1, returns the cached word and issues no memory request.
- R4: The tag is the full 20-bit physical frame. A read to a valid line whose frame differs is a miss, and the refill replaces the line, so the earlier frame then misses.
- R5: While the translation valid input is low, the access stays in the lookup stage, with no response and no memory request.
- R6: When translation reports a fault, the response carries fault=1 and hit=0. No memory request is issued and the cached line is left intact.
- R7: A write issues one memory write carrying the full byte address {frame, offset}, the data and the byte strobe. A write miss does not allocate, so a later read of that address still misses.
- R8: A write that hits updates only the strobed bytes of the cached word. A later read hit returns the merged word.
- R9: A response stays valid with stable data, hit and fault until it is accepted. A memory request stays valid with a stable address until accepted. No response or memory request is active while a new request can be accepted.
- R10: Address bits 1:0 (byte select) take no part in line selection or the tag match. Reads that differ only in those bits hit the same line.
- R11: A read hit responds one cycle after translation becomes valid. With translation valid in the cycle after acceptance, the response is visible one clock edge after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_offset | input | 12 | Untranslated page offset of the access |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_wstrb | input | 4 | Store byte enables |
| xlat_valid | input | 1 | Translation result present |
| xlat_fault | input | 1 | Translation failed for this access |
| xlat_frame | input | 20 | Translated physical frame number |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor accepts the response |
| cpu_rsp_rdata | output | 32 | Load data |
| cpu_rsp_hit | output | 1 | Access hit in the cache |
| cpu_rsp_fault | output | 1 | Access ended on a translation fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Physical address of the memory request |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_wstrb | output | 4 | Memory write byte enables |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | 32 | Memory read data |

## Verification
The bench sweeps every one of the 1024 lines: first as cold misses, then as hits with rotating byte-select bits and translation delays, then as conflicts from a second frame on alternate lines. This exposes index bits taken from the wrong place, which would alias lines, and a tag narrower than the frame, which would let the wrong frame hit. It also exposes valid bits that survive reset, which would report hits on garbage. Faulting translations are aimed at a resident line. A design that let a stale tag match through would report a hit or fetch from memory there. A write miss followed by a read of the same address catches an allocate-on-write. A partial-strobe write hit followed by a read catches a merge that overwrites unstrobed bytes. Stalled translations and held responses check that nothing leaks out early and that response fields do not change before acceptance.

// File: rtl/vipt_pkg.sv
// Package: shared types for the virtually indexed physically tagged cache.
// Assumes: a single outstanding access at a time.
package vipt_pkg;

    // Access sequencer states
    typedef enum logic [2:0] {
        CS_IDLE   = 3'd0,  // waiting for a processor request
        CS_LOOKUP = 3'd1,  // arrays read, waiting for translation
        CS_MREQ   = 3'd2,  // memory request presented
        CS_MWAIT  = 3'd3,  // waiting for memory read data
        CS_RESP   = 3'd4   // response presented to processor
    } vipt_state_e;

endpackage

// File: rtl/vipt_line_store.sv
// Module: line storage holding valid bits, physical tags and data words.
// Reads are registered and launched from the untranslated index; the
// write port takes a byte mask. Assumes reads and writes never target the
// same cycle (the sequencer serialises them).
module vipt_line_store #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [INDEX_W-1:0]  rd_idx,
    output logic                rd_valid,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [INDEX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_mask
);
    localparam int LINES  = 1 << INDEX_W;
    localparam int NBYTES = DATA_W / 8;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    // Valid bits: cleared by reset, set on any line write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: written through the masked write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_mask[b]) begin
                    data_mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end

    // Registered read launched from the untranslated index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
            rd_data  <= '0;
        end else if (rd_en) begin
            rd_valid <= valid_q[rd_idx];
            rd_tag   <= tag_mem[rd_idx];
            rd_data  <= data_mem[rd_idx];
        end
    end

endmodule

// File: rtl/vipt_tag_compare.sv
// Module: decides hit and fault once the translated frame is present.
// Assumes the wanted tag is already formed from the physical address.
module vipt_tag_compare #(
    parameter int TAG_W = 20
) (
    input  logic             xlat_valid,
    input  logic             xlat_fault,
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             hit,
    output logic             fault
);
    // A fault masks any stale tag match
    always_comb begin
        fault = xlat_valid && xlat_fault;
        hit   = xlat_valid && !xlat_fault && line_valid && (line_tag == want_tag);
    end

endmodule

// File: rtl/vipt_seq.sv
// Module: access sequencer. Accepts one request, waits for translation,
// chooses hit response, memory read with refill, or memory write, and
// holds the response until it is taken. Assumes one access in flight.
module vipt_seq
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic xlat_valid,
    input  logic hit,
    input  logic fault,
    input  logic mem_ready,
    input  logic mem_rsp_valid,
    input  logic rsp_ready,
    output logic req_ready,
    output logic accept,
    output logic lookup_go,
    output logic wr_hit_en,
    output logic fill_en,
    output logic mem_valid,
    output logic rsp_valid
);
    vipt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state choice
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (req_valid) state_d = CS_LOOKUP;
            CS_LOOKUP: if (xlat_valid) begin
                           if (fault)          state_d = CS_RESP;
                           else if (req_write) state_d = CS_MREQ;
                           else if (hit)       state_d = CS_RESP;
                           else                state_d = CS_MREQ;
                       end
            CS_MREQ:   if (mem_ready) state_d = req_write ? CS_RESP : CS_MWAIT;
            CS_MWAIT:  if (mem_rsp_valid) state_d = CS_RESP;
            CS_RESP:   if (rsp_ready) state_d = CS_IDLE;
            default:   state_d = CS_IDLE;
        endcase
    end

    // Strobes decoded from the current state
    always_comb begin
        req_ready = (state_q == CS_IDLE);
        accept    = req_ready && req_valid;
        lookup_go = (state_q == CS_LOOKUP) && xlat_valid;
        wr_hit_en = lookup_go && req_write && hit;
        mem_valid = (state_q == CS_MREQ);
        fill_en   = (state_q == CS_MWAIT) && mem_rsp_valid;
        rsp_valid = (state_q == CS_RESP);
    end

endmodule

// File: rtl/vipt_cache.sv
// Module: direct-mapped data cache, virtually indexed and physically tagged.
// The arrays are read from the page offset at acceptance; the tag compare
// uses the frame number delivered by translation one or more cycles later.
// Reads allocate; writes go through to memory and never allocate.
// Assumes the cache is no larger than a page (checked at elaboration).
module vipt_cache #(
    parameter int CACHE_BYTES = 4096,
    parameter int LINE_BYTES  = 4,
    parameter int PAGE_BITS   = 12,
    parameter int PA_BITS     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req_valid,
    output logic                   cpu_req_ready,
    input  logic                   cpu_req_write,
    input  logic [PAGE_BITS-1:0]   cpu_req_offset,
    input  logic [8*LINE_BYTES-1:0] cpu_req_wdata,
    input  logic [LINE_BYTES-1:0]  cpu_req_wstrb,
    input  logic                   xlat_valid,
    input  logic                   xlat_fault,
    input  logic [PA_BITS-PAGE_BITS-1:0] xlat_frame,
    output logic                   cpu_rsp_valid,
    input  logic                   cpu_rsp_ready,
    output logic [8*LINE_BYTES-1:0] cpu_rsp_rdata,
    output logic                   cpu_rsp_hit,
    output logic                   cpu_rsp_fault,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic                   mem_req_write,
    output logic [PA_BITS-1:0]     mem_req_addr,
    output logic [8*LINE_BYTES-1:0] mem_req_wdata,
    output logic [LINE_BYTES-1:0]  mem_req_wstrb,
    input  logic                   mem_rsp_valid,
    input  logic [8*LINE_BYTES-1:0] mem_rsp_rdata
);
    localparam int DATA_W  = 8 * LINE_BYTES;
    localparam int BSEL_W  = $clog2(LINE_BYTES);
    localparam int LINES   = CACHE_BYTES / LINE_BYTES;
    localparam int INDEX_W = $clog2(LINES);
    localparam int FRAME_W = PA_BITS - PAGE_BITS;
    localparam int TAG_W   = PA_BITS - INDEX_W - BSEL_W;

    // Size guard: the index must come from untranslated bits only
    generate
        if (INDEX_W + BSEL_W > PAGE_BITS) begin : g_size_guard
            $error("vipt_cache: cache larger than a page needs a translated index bit");
        end
    endgenerate

    logic                 accept, lookup_go, wr_hit_en, fill_en;
    logic                 line_valid, hit, fault;
    logic [TAG_W-1:0]     line_tag, want_tag;
    logic [DATA_W-1:0]    line_data;
    logic [PAGE_BITS-1:0] off_q;
    logic                 write_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [LINE_BYTES-1:0] wstrb_q;
    logic [FRAME_W-1:0]   frame_q, tag_frame;
    logic [PA_BITS-1:0]   phys_addr;
    logic [DATA_W-1:0]    rsp_data_q;
    logic                 rsp_hit_q, rsp_fault_q;
    logic                 st_wr_en;
    logic [DATA_W-1:0]    st_wr_data;
    logic [LINE_BYTES-1:0] st_wr_mask;

    // Physical address from the frame in use and the held offset
    always_comb begin
        tag_frame = lookup_go ? xlat_frame : frame_q;
        phys_addr = {tag_frame, off_q};
        want_tag  = phys_addr[PA_BITS-1 -: TAG_W];
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            wstrb_q <= '0;
        end else if (accept) begin
            off_q   <= cpu_req_offset;
            write_q <= cpu_req_write;
            wdata_q <= cpu_req_wdata;
            wstrb_q <= cpu_req_wstrb;
        end
    end

    // Frame capture once translation is valid
    always_ff @(posedge clk) begin
        if (!rst_n)         frame_q <= '0;
        else if (lookup_go) frame_q <= xlat_frame;
    end

    // Response fields: set at lookup, overwritten by refill data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_q  <= '0;
            rsp_hit_q   <= 1'b0;
            rsp_fault_q <= 1'b0;
        end else if (lookup_go) begin
            rsp_data_q  <= (hit && !write_q) ? line_data : '0;
            rsp_hit_q   <= hit;
            rsp_fault_q <= fault;
        end else if (fill_en) begin
            rsp_data_q  <= mem_rsp_rdata;
        end
    end

    // Store write port: byte merge on write hit, full word on refill
    always_comb begin
        st_wr_en   = wr_hit_en || fill_en;
        st_wr_data = fill_en ? mem_rsp_rdata : wdata_q;
        st_wr_mask = fill_en ? {LINE_BYTES{1'b1}} : wstrb_q;
    end

    vipt_line_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (accept),
        .rd_idx   (cpu_req_offset[BSEL_W +: INDEX_W]),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (line_data),
        .wr_en    (st_wr_en),
        .wr_idx   (off_q[BSEL_W +: INDEX_W]),
        .wr_tag   (want_tag),
        .wr_data  (st_wr_data),
        .wr_mask  (st_wr_mask)
    );

    vipt_tag_compare #(
        .TAG_W (TAG_W)
    ) cmp_i (
        .xlat_valid (xlat_valid),
        .xlat_fault (xlat_fault),
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .want_tag   (want_tag),
        .hit        (hit),
        .fault      (fault)
    );

    vipt_seq seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (cpu_req_valid),
        .req_write     (write_q),
        .xlat_valid    (xlat_valid),
        .hit           (hit),
        .fault         (fault),
        .mem_ready     (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_ready     (cpu_rsp_ready),
        .req_ready     (cpu_req_ready),
        .accept        (accept),
        .lookup_go     (lookup_go),
        .wr_hit_en     (wr_hit_en),
        .fill_en       (fill_en),
        .mem_valid     (mem_req_valid),
        .rsp_valid     (cpu_rsp_valid)
    );

    // Memory side: reads are word aligned, writes carry the byte address
    always_comb begin
        mem_req_write = write_q;
        mem_req_addr  = write_q ? phys_addr
                                : {phys_addr[PA_BITS-1:BSEL_W], {BSEL_W{1'b0}}};
        mem_req_wdata = wdata_q;
        mem_req_wstrb = write_q ? wstrb_q : {LINE_BYTES{1'b1}};
    end

    // Processor response outputs
    always_comb begin
        cpu_rsp_rdata = rsp_data_q;
        cpu_rsp_hit   = rsp_hit_q;
        cpu_rsp_fault = rsp_fault_q;
    end

endmodule

// File: rtl/vipt_cache_chk.sv
// Module: protocol checker for vipt_cache, attached by bind.
// Assumes the default 32-bit data and address widths at the ports it sees.
module vipt_cache_chk #(
    parameter int DATA_W  = 32,
    parameter int PA_BITS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_ready,
    input logic              xlat_valid,
    input logic              cpu_rsp_valid,
    input logic              cpu_rsp_ready,
    input logic [DATA_W-1:0] cpu_rsp_rdata,
    input logic              cpu_rsp_hit,
    input logic              cpu_rsp_fault,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [PA_BITS-1:0] mem_req_addr
);
    // R9: memory request held with stable address until accepted
    a_r9_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    // R9: response held with stable fields until accepted
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid && !cpu_rsp_ready |=>
            cpu_rsp_valid && $stable(cpu_rsp_rdata) && $stable(cpu_rsp_hit)
            && $stable(cpu_rsp_fault));

    // R9: nothing outstanding while a new request may be taken
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_ready |-> !mem_req_valid && !cpu_rsp_valid);

    // R6: a faulting response never claims a hit
    a_r6_fault_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid && cpu_rsp_fault |-> !cpu_rsp_hit);

    // R5: a memory request only starts after translation was valid
    a_r5_mem_after_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(xlat_valid));

endmodule

bind vipt_cache vipt_cache_chk #(
    .DATA_W  (8*LINE_BYTES),
    .PA_BITS (PA_BITS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_ready (cpu_req_ready),
    .xlat_valid    (xlat_valid),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_ready (cpu_rsp_ready),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .cpu_rsp_hit   (cpu_rsp_hit),
    .cpu_rsp_fault (cpu_rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/vipt_cache_tb_top.sv
// Bench: sweeps every line of the default 4 KB configuration through
// cold misses, hits, frame conflicts, faults and write-through cases.
module vipt_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [11:0] cpu_req_offset = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic [3:0]  cpu_req_wstrb = '0;
    logic        xlat_valid = 1'b0;
    logic        xlat_fault = 1'b0;
    logic [19:0] xlat_frame = '0;
    logic        cpu_rsp_valid;
    logic        cpu_rsp_ready = 1'b0;
    logic [31:0] cpu_rsp_rdata;
    logic        cpu_rsp_hit;
    logic        cpu_rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [3:0]  mem_req_wstrb;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;

    localparam logic [19:0] F1 = 20'h12345;
    localparam logic [19:0] F2 = 20'hABCDE;
    localparam logic [19:0] F3 = 20'h00F0F;

    always #10 clk = ~clk;  // 50 MHz

    vipt_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_offset(cpu_req_offset),
        .cpu_req_wdata(cpu_req_wdata), .cpu_req_wstrb(cpu_req_wstrb),
        .xlat_valid(xlat_valid), .xlat_fault(xlat_fault), .xlat_frame(xlat_frame),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
        .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_hit(cpu_rsp_hit),
        .cpu_rsp_fault(cpu_rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_wstrb(mem_req_wstrb),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Memory contents as a pure function of the word address
    function automatic logic [31:0] mdata(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h1357_2468;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old_w,
                                          input logic [31:0] new_w,
                                          input logic [3:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[8*b +: 8] = s[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // Memory model: ready pattern, two-cycle read latency, write recording
    int          rdy_ctr = 0;
    int          mem_rd_cnt = 0;
    int          mem_wr_cnt = 0;
    logic [31:0] last_raddr = '0;
    logic [31:0] last_waddr = '0;
    logic [31:0] last_wdata = '0;
    logic [3:0]  last_wstrb = '0;
    bit          pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;

    always @(negedge clk) begin
        rdy_ctr++;
        mem_req_ready = (rdy_ctr % 3) != 0;
    end

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem_wr_cnt++;
                last_waddr = mem_req_addr;
                last_wdata = mem_req_wdata;
                last_wstrb = mem_req_wstrb;
            end else begin
                mem_rd_cnt++;
                last_raddr = mem_req_addr;
                pend  = 1'b1;
                pcnt  = 2;
                paddr = mem_req_addr;
            end
        end
        if (pend) begin
            if (pcnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mdata(paddr);
                pend = 1'b0;
            end else begin
                pcnt--;
            end
        end
    end

    // One access: dly = cycles translation is withheld, hold = cycles the
    // response is left unaccepted; lat = edges from acceptance to response
    task automatic access(input bit wr, input logic [11:0] off,
                          input logic [19:0] frame, input logic [31:0] wd,
                          input logic [3:0] ws, input int dly, input bit flt,
                          input int hold, output logic [31:0] rd,
                          output bit h, output bit f, output int lat);
        bit leak = 1'b0;
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid  = 1'b1;
        cpu_req_write  = wr;
        cpu_req_offset = off;
        cpu_req_wdata  = wd;
        cpu_req_wstrb  = ws;
        xlat_valid     = 1'b0;
        xlat_frame     = frame;
        xlat_fault     = flt;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 0;
        forever begin
            xlat_valid = (lat >= dly);
            if (cpu_rsp_valid) break;
            if (lat < dly && mem_req_valid) leak = 1'b1;
            if (lat > 500) break;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        // R5: no response or memory request while translation is withheld
        if (dly > 0) check(!leak, "R5", "activity during stall", {31'b0, leak}, 32'h0);
        rd = cpu_rsp_rdata;
        h  = cpu_rsp_hit;
        f  = cpu_rsp_fault;
        for (int k = 0; k < hold; k++) begin
            @(posedge clk);
            @(negedge clk);
            // R9: response held unchanged until accepted
            check(cpu_rsp_valid && cpu_rsp_rdata == rd && cpu_rsp_hit == h,
                  "R9", "held response", cpu_rsp_rdata, rd);
        end
        cpu_rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_rsp_ready = 1'b0;
        xlat_valid    = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] a;
        bit h, f;
        int lat, r0, w0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(cpu_req_ready == 1'b1, "R1", "ready after reset", {31'b0, cpu_req_ready}, 32'h1);
        check(!cpu_rsp_valid && !mem_req_valid, "R1", "quiet after reset",
              {30'b0, cpu_rsp_valid, mem_req_valid}, 32'h0);

        // Sweep A: cold misses on every line (R1, R2)
        for (int i = 0; i < 1024; i++) begin
            a  = {F1, i[9:0], 2'b00};
            r0 = mem_rd_cnt;
            access(1'b0, a[11:0], F1, 32'h0, 4'h0, i % 2, 1'b0, (i % 97 == 0) ? 2 : 0,
                   rd, h, f, lat);
            check(!h, "R1", "cold read hit flag", {31'b0, h}, 32'h0);
            check(rd == mdata(a), "R2", "miss data", rd, mdata(a));
            check(mem_rd_cnt == r0 + 1 && last_raddr == a, "R2", "miss address",
                  last_raddr, a);
        end

        // Sweep B: hits with rotating byte select and translation delay (R3, R10, R11)
        for (int i = 0; i < 1024; i++) begin
            a  = {F1, i[9:0], i[1:0]};
            r0 = mem_rd_cnt;
            access(1'b0, a[11:0], F1, 32'h0, 4'h0, i % 3, 1'b0, 0, rd, h, f, lat);
            check(h, "R3", "hit flag", {31'b0, h}, 32'h1);
            check(rd == mdata(a), "R10", "hit data with byte select", rd, mdata(a));
            check(mem_rd_cnt == r0, "R3", "no memory read on hit", mem_rd_cnt, r0);
            check(lat == (i % 3) + 1, "R11", "hit latency", lat, (i % 3) + 1);
        end

        // Sweep C: second frame on even lines, then first frame again (R4)
        for (int i = 0; i < 1024; i += 2) begin
            a = {F2, i[9:0], 2'b00};
            access(1'b0, a[11:0], F2, 32'h0, 4'h0, 0, 1'b0, 0, rd, h, f, lat);
            check(!h && rd == mdata(a), "R4", "other frame misses", rd, mdata(a));
        end
        for (int i = 0; i < 1024; i++) begin
            a = {F1, i[9:0], 2'b00};
            access(1'b0, a[11:0], F1, 32'h0, 4'h0, 0, 1'b0, 0, rd, h, f, lat);
            check(h == (i % 2 == 1), "R4", "evicted frame hit flag", {31'b0, h},
                  {31'b0, (i % 2 == 1)});
            check(rd == mdata(a), "R4", "data after eviction", rd, mdata(a));
        end

        // R6: translation fault on a resident line
        a  = {F1, 10'd5, 2'b00};
        r0 = mem_rd_cnt;
        w0 = mem_wr_cnt;
        access(1'b0, a[11:0], F1, 32'h0, 4'h0, 1, 1'b1, 1, rd, h, f, lat);
        check(f && !h, "R6", "fault response", {30'b0, f, h}, 32'h2);
        check(mem_rd_cnt == r0 && mem_wr_cnt == w0, "R6", "no memory on fault",
              mem_rd_cnt, r0);
        access(1'b0, a[11:0], F1, 32'h0, 4'h0, 0, 1'b0, 0, rd, h, f, lat);
        check(h && !f && rd == mdata(a), "R6", "line kept after fault", rd, mdata(a));

        // R7: write miss goes through without allocating
        a  = {F3, 10'd7, 2'b11};
        w0 = mem_wr_cnt;
        access(1'b1, a[11:0], F3, 32'hCAFE_F00D, 4'b1000, 0, 1'b0, 0, rd, h, f, lat);
        check(mem_wr_cnt == w0 + 1, "R7", "write issued", mem_wr_cnt, w0 + 1);
        check(last_waddr == a, "R7", "write address", last_waddr, a);
        check(last_wdata == 32'hCAFE_F00D && last_wstrb == 4'b1000, "R7",
              "write data", last_wdata, 32'hCAFE_F00D);
        check(!h, "R7", "write miss flag", {31'b0, h}, 32'h0);
        access(1'b0, a[11:0], F3, 32'h0, 4'h0, 0, 1'b0, 0, rd, h, f, lat);
        check(!h, "R7", "no allocate on write", {31'b0, h}, 32'h0);

        // R8: partial write hit merges bytes
        a  = {F1, 10'd9, 2'b00};
        w0 = mem_wr_cnt;
        access(1'b1, a[11:0], F1, 32'h1122_3344, 4'b0101, 2, 1'b0, 0, rd, h, f, lat);
        check(h && mem_wr_cnt == w0 + 1, "R8", "write hit goes through",
              {31'b0, h}, 32'h1);
        access(1'b0, a[11:0], F1, 32'h0, 4'h0, 0, 1'b0, 0, rd, h, f, lat);
        check(h && rd == merge(mdata(a), 32'h1122_3344, 4'b0101), "R8",
              "merged word", rd, merge(mdata(a), 32'h1122_3344, 4'b0101));

        summary();
        $finish;
    end

endmodule